// File: doc/BRIEF.md
# Single-Clock Queue with Handshake, Error and Threshold Flags

This block is a first-in first-out store in which writer and reader share one clock. The data width and the number of entries are fixed at elaboration. The writer asserts a write enable with a data word. The reader asserts a read enable. Each side gets back a one-cycle acknowledge for a request that was carried out, or a one-cycle error pulse for a request that could not be honoured. A write into a full store is dropped, so no stored word is overwritten. A read from an empty store pops nothing.

The current occupancy is exported, together with full and empty flags. Two programmable thresholds give a high flag and a low flag. A sticky interrupt collects two kinds of event: error pulses, and the occupancy crossing one of the thresholds. Each kind has its own enable, and a clear input drops the interrupt.

The depth should cover the worst burst. That case is a writer sending B words back to back while the reader drains at its slowest rate. For example, a 30 MHz writer and a 40 MHz reader that takes one word every other cycle leave about a third of the burst to be held. A 10-word burst therefore needs 4 entries, which is the default depth.

Top module: `syncq_top`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the block comes out of that edge with `level` 0, `empty` 1, `full` 0, and `wrAck`, `rdAck`, `wrErr`, `rdErr`, `irq` and `rdData` all 0.
- R2: Words leave in the order they were accepted. The word popped by a read request sampled at edge k is on `rdData` after edge k, and `rdData` holds its value until the next accepted read.
- R3: A read is accepted when occupancy is nonzero. A write is accepted when occupancy is below DEPTH, or when a read is accepted in the same cycle. Each accepted request gives a one-cycle `wrAck` or `rdAck` after the edge that sampled it.
- R4: A write request that is not accepted gives a one-cycle `wrErr`. The word is discarded and occupancy is not raised by it.
- R5: A read request while empty gives a one-cycle `rdErr`, leaves occupancy and `rdData` unchanged, and gives no `rdAck`.
- R6: When full, a simultaneous read and write both succeed, both acknowledge, and occupancy stays at DEPTH.
- R7: When empty, a simultaneous read and write performs only the write, flags `rdErr`, and leaves occupancy at 1.
- R8: `level` equals accepted writes minus accepted reads since reset. `full` is high exactly when `level` equals DEPTH, and `empty` is high exactly when `level` is 0.
- R9: `hiFlag` is high when `level` is greater than or equal to `hiMark`. `loFlag` is high when `level` is less than or equal to `loMark`.
- R10: When `errIrqEn` is high, any `wrErr` or `rdErr` event sets `irq` after the same edge. `irq` then stays high until an edge with `irqClr` high and no new setting event.
- R11: When `markIrqEn` is high, `irq` is set by two kinds of step. One is a write-only step that brings occupancy up to exactly `hiMark`. The other is a read-only step that brings occupancy down to exactly `loMark`.
- R12: With an enable low, its event class never sets `irq`.
- R13: A setting event in the same cycle as `irqClr` wins, and `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Read request |
| hiMark | input | CNT_W | High occupancy threshold |
| loMark | input | CNT_W | Low occupancy threshold |
| errIrqEn | input | 1 | Lets error events set the interrupt |
| markIrqEn | input | 1 | Lets threshold crossings set the interrupt |
| irqClr | input | 1 | Clears the sticky interrupt |
| wrAck | output | 1 | Accepted-write pulse |
| wrErr | output | 1 | Rejected-write pulse |
| rdAck | output | 1 | Accepted-read pulse, marks valid rdData |
| rdErr | output | 1 | Rejected-read pulse |
| rdData | output | DATA_W | Registered read word |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| level | output | CNT_W | Current occupancy |
| hiFlag | output | 1 | Occupancy at or above hiMark |
| loFlag | output | 1 | Occupancy at or below loMark |
| irq | output | 1 | Sticky interrupt |

## Verification
The registered results are `wrAck`, `wrErr`, `rdAck`, `rdErr`, `rdData`, `level` and `irq`. Each is due one edge after the request, and the bench compares them at the falling edge that follows that rising edge. `full`, `empty`, `hiFlag` and `loFlag` follow from `level` and the threshold inputs without further delay, so they are compared at the same falling edge. The bench drives every input at a falling edge. It computes the expectations from an arithmetic queue model before the edge and advances the model after the comparison, so each expectation belongs to exactly one edge. All threshold pairs are swept for depth 4, under write-heavy, balanced and read-heavy traffic.

// File: rtl/syncq_pkg.sv
package syncq_pkg;

  // Strobes issued by the control to the storage datapath.
  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;

endpackage

// File: rtl/syncq_store.sv
module syncq_store
  import syncq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  qStrobe_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] outQ;

  // Storage array: the pop samples the old word even when the push hits the same slot.
  always_ff @(posedge clk) begin
    if (stb.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)          outQ <= '0;
    else if (stb.pop) outQ <= mem[rdAddr];
  end

  assign rdData = outQ;

endmodule

// File: rtl/syncq_ctrl.sv
module syncq_ctrl
  import syncq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [CNT_W-1:0]  hiMark,
  input  logic [CNT_W-1:0]  loMark,
  input  logic              errIrqEn,
  input  logic              markIrqEn,
  input  logic              irqClr,
  output qStrobe_t          stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrAck,
  output logic              wrErr,
  output logic              rdAck,
  output logic              rdErr,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  level,
  output logic              hiFlag,
  output logic              loFlag,
  output logic              irq
);

  localparam logic [CNT_W-1:0] LEVEL_MAX = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] wrPtr, rdPtr, wrPtrNext, rdPtrNext;
  logic [CNT_W-1:0]  levelQ, levelNext;
  logic              rdOk, wrOk;
  logic              hiEvt, loEvt, errEvt, irqSet;
  logic              wrAckQ, wrErrQ, rdAckQ, rdErrQ, irqQ;

  // Acceptance: a read needs data; a write needs space or a paired read.
  assign rdOk = rdEn && (levelQ != '0);
  assign wrOk = wrEn && ((levelQ != LEVEL_MAX) || rdOk);

  // Pointer advance: a power-of-two depth wraps naturally, other depths compare.
  generate
    if ((1 << ADDR_W) == DEPTH) begin : g_wrapPow2
      assign wrPtrNext = wrPtr + ADDR_W'(1);
      assign rdPtrNext = rdPtr + ADDR_W'(1);
    end else begin : g_wrapCmp
      assign wrPtrNext = (wrPtr == ADDR_W'(DEPTH - 1)) ? '0 : wrPtr + ADDR_W'(1);
      assign rdPtrNext = (rdPtr == ADDR_W'(DEPTH - 1)) ? '0 : rdPtr + ADDR_W'(1);
    end
  endgenerate

  always_comb begin
    levelNext = levelQ;
    unique case ({wrOk, rdOk})
      2'b10:   levelNext = levelQ + CNT_W'(1);
      2'b01:   levelNext = levelQ - CNT_W'(1);
      default: levelNext = levelQ;
    endcase
  end

  // Interrupt sources: rejected requests and threshold crossings.
  assign errEvt = (wrEn && !wrOk) || (rdEn && !rdOk);
  assign hiEvt  = wrOk && !rdOk && (levelNext == hiMark);
  assign loEvt  = rdOk && !wrOk && (levelNext == loMark);
  assign irqSet = (errIrqEn && errEvt) || (markIrqEn && (hiEvt || loEvt));

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      levelQ <= '0;
      wrAckQ <= 1'b0;
      wrErrQ <= 1'b0;
      rdAckQ <= 1'b0;
      rdErrQ <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      if (wrOk) wrPtr <= wrPtrNext;
      if (rdOk) rdPtr <= rdPtrNext;
      levelQ <= levelNext;
      wrAckQ <= wrOk;
      wrErrQ <= wrEn && !wrOk;
      rdAckQ <= rdOk;
      rdErrQ <= rdEn && !rdOk;
      irqQ   <= irqSet || (irqQ && !irqClr);
    end
  end

  assign stb.push = wrOk;
  assign stb.pop  = rdOk;
  assign wrAddr   = wrPtr;
  assign rdAddr   = rdPtr;

  assign wrAck  = wrAckQ;
  assign wrErr  = wrErrQ;
  assign rdAck  = rdAckQ;
  assign rdErr  = rdErrQ;
  assign irq    = irqQ;
  assign level  = levelQ;
  assign full   = (levelQ == LEVEL_MAX);
  assign empty  = (levelQ == '0);
  assign hiFlag = (levelQ >= hiMark);
  assign loFlag = (levelQ <= loMark);

endmodule

// File: rtl/syncq_top.sv
module syncq_top
  import syncq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [CNT_W-1:0]  hiMark,
  input  logic [CNT_W-1:0]  loMark,
  input  logic              errIrqEn,
  input  logic              markIrqEn,
  input  logic              irqClr,
  output logic              wrAck,
  output logic              wrErr,
  output logic              rdAck,
  output logic              rdErr,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  level,
  output logic              hiFlag,
  output logic              loFlag,
  output logic              irq
);

  qStrobe_t          stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  syncq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn),
    .hiMark(hiMark), .loMark(loMark),
    .errIrqEn(errIrqEn), .markIrqEn(markIrqEn), .irqClr(irqClr),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrAck(wrAck), .wrErr(wrErr), .rdAck(rdAck), .rdErr(rdErr),
    .full(full), .empty(empty), .level(level),
    .hiFlag(hiFlag), .loFlag(loFlag), .irq(irq)
  );

  syncq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uStore (
    .clk(clk), .rst(rst), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/syncq_chk.sv
module syncq_chk #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic             rdEn,
  input logic             errIrqEn,
  input logic             markIrqEn,
  input logic             irqClr,
  input logic             wrAck,
  input logic             wrErr,
  input logic             rdAck,
  input logic             rdErr,
  input logic             full,
  input logic             empty,
  input logic [CNT_W-1:0] level,
  input logic             irq
);

  a_r8_not_full_and_empty: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  a_r8_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= CNT_W'(DEPTH));

  a_r4_full_write_rejected: assert property (@(posedge clk) disable iff (rst)
    (full && wrEn && !rdEn) |=> (wrErr && !wrAck && $stable(level)));

  a_r5_empty_read_rejected: assert property (@(posedge clk) disable iff (rst)
    (empty && rdEn) |=> (rdErr && !rdAck));

  a_r6_full_pass_through: assert property (@(posedge clk) disable iff (rst)
    (full && wrEn && rdEn) |=> (wrAck && rdAck && full));

  a_r3_ack_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wrAck && wrErr) && !(rdAck && rdErr));

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !irqClr) |=> irq);

  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!errIrqEn && !markIrqEn && !irq) |=> !irq);

endmodule

bind syncq_top syncq_chk #(.DEPTH(DEPTH)) uChk (.*);

// File: tb/sim_syncq_top.sv
`timescale 1ns/1ps
module sim_syncq_top;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [CNT_W-1:0] hiMark = CNT_W'(3), loMark = CNT_W'(1);
  logic errIrqEn = 1'b0, markIrqEn = 1'b0, irqClr = 1'b0;
  logic wrAck, wrErr, rdAck, rdErr, full, empty, hiFlag, loFlag, irq;
  logic [DATA_W-1:0] rdData;
  logic [CNT_W-1:0] level;

  always #2.5 clk = ~clk;

  syncq_top #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (.*);

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Arithmetic model of the queue.
  int mq [64];
  int mHead = 0, mTail = 0, mCnt = 0;
  int expData = 0;
  bit expIrq = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle of stimulus, compare after the edge, then advance the model.
  task automatic step(input bit w, input bit r, input int d,
                      input bit eEn, input bit mEn, input bit clr);
    bit rOk, wOk, hiE, loE, evt;
    int nCnt;
    wrEn = w; rdEn = r; wrData = DATA_W'(d);
    errIrqEn = eEn; markIrqEn = mEn; irqClr = clr;
    rOk  = r && (mCnt > 0);
    wOk  = w && ((mCnt < DEPTH) || rOk);
    nCnt = mCnt + int'(wOk) - int'(rOk);
    hiE  = wOk && !rOk && (nCnt == int'(hiMark));
    loE  = rOk && !wOk && (nCnt == int'(loMark));
    evt  = (eEn && ((w && !wOk) || (r && !rOk))) || (mEn && (hiE || loE));
    if (rOk) begin expData = mq[mHead]; mHead = (mHead + 1) % 64; end
    if (wOk) begin mq[mTail] = d & 8'hFF; mTail = (mTail + 1) % 64; end
    mCnt   = nCnt;
    expIrq = evt || (expIrq && !clr);
    @(negedge clk);
    chk("R3 wrAck", int'(wrAck), int'(wOk));
    chk("R4 wrErr", int'(wrErr), int'(w && !wOk));
    chk("R3 rdAck", int'(rdAck), int'(rOk));
    chk("R5 rdErr", int'(rdErr), int'(r && !rOk));
    chk("R2 rdData", int'(rdData), expData);
    chk("R8 level", int'(level), mCnt);
    chk("R8 full", int'(full), int'(mCnt == DEPTH));
    chk("R8 empty", int'(empty), int'(mCnt == 0));
    chk("R9 hiFlag", int'(hiFlag), int'(mCnt >= int'(hiMark)));
    chk("R9 loFlag", int'(loFlag), int'(mCnt <= int'(loMark)));
    chk("R10 irq", int'(irq), int'(expIrq));
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    int dv = 1;
    repeat (3) @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 level", int'(level), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 acks/errs", int'({wrAck, rdAck, wrErr, rdErr}), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rdData", int'(rdData), 0);
    rst = 1'b0;

    // R5: read while empty, errors enabled -> R10 irq set
    step(0, 1, 0, 1, 0, 0);
    // R13: clear together with a new error keeps irq
    step(0, 1, 0, 1, 0, 1);
    // R10: plain clear drops irq
    step(0, 0, 0, 1, 0, 1);
    // R7: empty with both requests
    step(1, 1, 8'h11, 0, 0, 0);
    // fill to full with R11 crossing enabled (hiMark 3)
    step(1, 0, 8'h22, 0, 1, 0);
    step(1, 0, 8'h33, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    step(1, 0, 8'h44, 0, 1, 0);
    // R4: write while full, R12: errors masked
    step(1, 0, 8'h55, 0, 0, 0);
    // R6: full with both requests
    step(1, 1, 8'h66, 0, 0, 0);
    step(1, 1, 8'h77, 0, 0, 0);
    // drain in order (R2), with R11 low crossing at loMark 1
    for (int i = 0; i < DEPTH + 1; i++) step(0, 1, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);

    // Sweep over every threshold pair and three traffic mixes.
    for (int hi = 1; hi <= DEPTH; hi++) begin
      for (int lo = 0; lo < DEPTH; lo++) begin
        hiMark = CNT_W'(hi); loMark = CNT_W'(lo);
        for (int mix = 0; mix < 3; mix++) begin
          for (int n = 0; n < 40; n++) begin
            bit w, r;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (mix)
              0: begin w = lf[1:0] != 2'b00; r = lf[3:2] == 2'b00; end
              1: begin w = lf[0];            r = lf[2];            end
              default: begin w = lf[1:0] == 2'b00; r = lf[3:2] != 2'b00; end
            endcase
            step(w, r, dv, lf[4], lf[5], lf[7:6] == 2'b00);
            dv = (dv + 7) % 256;
          end
        end
      end
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule